// File: doc/BRIEF.md
# Staged Control Bundle Pipeline

This block turns the opcode of the instruction now in decode into control bits, sorted by the stage that uses them. There are three groups. The execute group holds destination select, a 2-bit ALU operation, operand-B source and branch. The memory group holds read and write enables. The writeback group holds register write and result-from-memory select.

All three groups are captured together in the decode/execute register. Only the memory and writeback groups move on into the execute/memory register, and only the writeback group reaches the memory/writeback register. Each stage register drives its own copy of its bits. On any cycle, for example, the register-write bit at the memory stage and the one at the writeback stage belong to different instructions.

A flush or bubble request turns the instruction entering execute into a harmless no-op. The datapath, hazard detection and ALU function decode sit outside this block.

Top module: `ctrl_pipe`

## Requirements
Bundle order used below: {reg_dst, alu_op[1:0], alu_src, branch, mem_rd, mem_wr, reg_wr, mem_to_reg}. A bundle captured at one rising edge appears at the decode/execute outputs until the next edge.
- R1: Opcode 6'h00 (register-register) yields bundle 9'b1_10_0_0_0_0_1_0.
- R2: Opcode 6'h23 (load) yields bundle 9'b0_00_1_0_1_0_1_1.
- R3: Opcode 6'h2B (store) yields bundle 9'b0_00_1_0_0_1_0_0. Memory read and memory write are never both set in one stage.
- R4: Opcode 6'h04 (branch on equal) yields bundle 9'b0_01_0_1_0_0_0_0. A branch never asserts register write or memory write.
- R5: Any other opcode yields the all-zero bundle.
- R6: When flush_i is high at an edge, the decode/execute register captures the all-zero bundle, whatever the opcode.
- R7: The execute/memory outputs {mem_rd, mem_wr, reg_wr, mem_to_reg} equal the decode/execute copies of those bits one cycle earlier. The execute group is not carried forward.
- R8: The memory/writeback outputs {reg_wr, mem_to_reg} equal the execute/memory copies one cycle earlier.
- R9: While rst_ni is low, every stage output is zero.
- R10: Each stage holds its own copy, so the same bit may differ between stages in the same cycle. An example is a store at the memory stage following a load at writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Insert a bubble into execute |
| opcode_i | input | 6 | Opcode of the instruction in decode |
| id_ex_reg_dst_o | output | 1 | Execute: destination from rd field |
| id_ex_alu_op_o | output | 2 | Execute: ALU operation class |
| id_ex_alu_src_o | output | 1 | Execute: operand B from immediate |
| id_ex_branch_o | output | 1 | Execute: branch instruction |
| id_ex_mem_rd_o | output | 1 | Decode/execute copy of memory read |
| id_ex_mem_wr_o | output | 1 | Decode/execute copy of memory write |
| id_ex_reg_wr_o | output | 1 | Decode/execute copy of register write |
| id_ex_mem_to_reg_o | output | 1 | Decode/execute copy of memory-to-register |
| ex_mem_mem_rd_o | output | 1 | Memory stage: read data memory |
| ex_mem_mem_wr_o | output | 1 | Memory stage: write data memory |
| ex_mem_reg_wr_o | output | 1 | Execute/memory copy of register write |
| ex_mem_mem_to_reg_o | output | 1 | Execute/memory copy of memory-to-register |
| mem_wb_reg_wr_o | output | 1 | Writeback: write register file |
| mem_wb_mem_to_reg_o | output | 1 | Writeback: select memory data |

## Verification
The hardest case to reach from the ports is a cycle where the three stages hold three different instructions, and copies of the same bit disagree. The stimulus therefore issues loads, stores, branches, register ops and unknown opcodes back to back, one per cycle, with flushes placed between them. The scoreboard aligns each stage against the bundle issued one and two cycles earlier. A second phase fills the pipe with loads and then asserts reset mid-run, to show that all copies clear at once.

// File: rtl/ctrl_pipe_pkg.sv
package ctrl_pipe_pkg;
  localparam int OPC_W    = 6;
  localparam int ALU_OP_W = 2;

  localparam logic [OPC_W-1:0] OPC_RR  = 6'h00;
  localparam logic [OPC_W-1:0] OPC_LD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_ST  = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_BEQ = 6'h04;

  localparam logic [ALU_OP_W-1:0] ALU_ADD  = 2'b00;
  localparam logic [ALU_OP_W-1:0] ALU_SUB  = 2'b01;
  localparam logic [ALU_OP_W-1:0] ALU_FUNC = 2'b10;

  typedef struct packed {
    logic                reg_dst;
    logic [ALU_OP_W-1:0] alu_op;
    logic                alu_src;
    logic                branch;
  } ex_ctrl_t;

  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
  } mem_ctrl_t;

  typedef struct packed {
    logic reg_wr;
    logic mem_to_reg;
  } wb_ctrl_t;

  typedef struct packed {
    ex_ctrl_t  ex;
    mem_ctrl_t mem;
    wb_ctrl_t  wb;
  } id_ex_t;

  typedef struct packed {
    mem_ctrl_t mem;
    wb_ctrl_t  wb;
  } ex_mem_t;

  typedef struct packed {
    wb_ctrl_t wb;
  } mem_wb_t;
endpackage

// File: rtl/ctrl_decode.sv
module ctrl_decode
  import ctrl_pipe_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output id_ex_t           ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    case (opc_i)
      OPC_RR: begin
        ctrl_o.ex.reg_dst = 1'b1;
        ctrl_o.ex.alu_op  = ALU_FUNC;
        ctrl_o.wb.reg_wr  = 1'b1;
      end
      OPC_LD: begin
        ctrl_o.ex.alu_op     = ALU_ADD;
        ctrl_o.ex.alu_src    = 1'b1;
        ctrl_o.mem.mem_rd    = 1'b1;
        ctrl_o.wb.reg_wr     = 1'b1;
        ctrl_o.wb.mem_to_reg = 1'b1;
      end
      OPC_ST: begin
        ctrl_o.ex.alu_op  = ALU_ADD;
        ctrl_o.ex.alu_src = 1'b1;
        ctrl_o.mem.mem_wr = 1'b1;
      end
      OPC_BEQ: begin
        ctrl_o.ex.alu_op = ALU_SUB;
        ctrl_o.ex.branch = 1'b1;
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/ctrl_stage_reg.sv
module ctrl_stage_reg #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/ctrl_pipe.sv
module ctrl_pipe
  import ctrl_pipe_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic [OPC_W-1:0]    opcode_i,
  output logic                id_ex_reg_dst_o,
  output logic [ALU_OP_W-1:0] id_ex_alu_op_o,
  output logic                id_ex_alu_src_o,
  output logic                id_ex_branch_o,
  output logic                id_ex_mem_rd_o,
  output logic                id_ex_mem_wr_o,
  output logic                id_ex_reg_wr_o,
  output logic                id_ex_mem_to_reg_o,
  output logic                ex_mem_mem_rd_o,
  output logic                ex_mem_mem_wr_o,
  output logic                ex_mem_reg_wr_o,
  output logic                ex_mem_mem_to_reg_o,
  output logic                mem_wb_reg_wr_o,
  output logic                mem_wb_mem_to_reg_o
);
  localparam int IDEX_W  = $bits(id_ex_t);
  localparam int EXMEM_W = $bits(ex_mem_t);
  localparam int MEMWB_W = $bits(mem_wb_t);

  id_ex_t  dec_ctrl, id_ex_d, id_ex_q;
  ex_mem_t ex_mem_d, ex_mem_q;
  mem_wb_t mem_wb_d, mem_wb_q;

  ctrl_decode u_dec (.opc_i(opcode_i), .ctrl_o(dec_ctrl));

  // bubble: nothing state-changing enters execute
  assign id_ex_d = flush_i ? '0 : dec_ctrl;

  // execute group retires at this boundary
  assign ex_mem_d.mem = id_ex_q.mem;
  assign ex_mem_d.wb  = id_ex_q.wb;

  // memory group retires at this boundary
  assign mem_wb_d.wb  = ex_mem_q.wb;

  ctrl_stage_reg #(.W(IDEX_W)) u_id_ex (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(id_ex_d), .q_o(id_ex_q)
  );
  ctrl_stage_reg #(.W(EXMEM_W)) u_ex_mem (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ex_mem_d), .q_o(ex_mem_q)
  );
  ctrl_stage_reg #(.W(MEMWB_W)) u_mem_wb (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(mem_wb_d), .q_o(mem_wb_q)
  );

  assign id_ex_reg_dst_o     = id_ex_q.ex.reg_dst;
  assign id_ex_alu_op_o      = id_ex_q.ex.alu_op;
  assign id_ex_alu_src_o     = id_ex_q.ex.alu_src;
  assign id_ex_branch_o      = id_ex_q.ex.branch;
  assign id_ex_mem_rd_o      = id_ex_q.mem.mem_rd;
  assign id_ex_mem_wr_o      = id_ex_q.mem.mem_wr;
  assign id_ex_reg_wr_o      = id_ex_q.wb.reg_wr;
  assign id_ex_mem_to_reg_o  = id_ex_q.wb.mem_to_reg;
  assign ex_mem_mem_rd_o     = ex_mem_q.mem.mem_rd;
  assign ex_mem_mem_wr_o     = ex_mem_q.mem.mem_wr;
  assign ex_mem_reg_wr_o     = ex_mem_q.wb.reg_wr;
  assign ex_mem_mem_to_reg_o = ex_mem_q.wb.mem_to_reg;
  assign mem_wb_reg_wr_o     = mem_wb_q.wb.reg_wr;
  assign mem_wb_mem_to_reg_o = mem_wb_q.wb.mem_to_reg;

  // assertions
  logic past_vld;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_vld <= 1'b0;
    else         past_vld <= 1'b1;
  end

  p_ex_mem_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld |-> (ex_mem_q.mem == $past(id_ex_q.mem)) && (ex_mem_q.wb == $past(id_ex_q.wb)));

  p_mem_wb_follows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld |-> mem_wb_q.wb == $past(ex_mem_q.wb));

  p_bubble_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld && $past(flush_i) |-> id_ex_q == '0);

  p_rd_wr_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(id_ex_q.mem.mem_rd && id_ex_q.mem.mem_wr) && !(ex_mem_q.mem.mem_rd && ex_mem_q.mem.mem_wr));

  p_branch_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_ex_q.ex.branch |-> !id_ex_q.wb.reg_wr && !id_ex_q.mem.mem_wr);

  p_unknown_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld && !$past(opcode_i == OPC_RR || opcode_i == OPC_LD ||
                       opcode_i == OPC_ST || opcode_i == OPC_BEQ) |-> id_ex_q == '0);
endmodule

// File: tb/ctrl_pipe_tb.sv
module ctrl_pipe_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       flush_i = 1'b0;
  logic [5:0] opcode_i = 6'h3F;
  logic       id_ex_reg_dst_o, id_ex_alu_src_o, id_ex_branch_o;
  logic [1:0] id_ex_alu_op_o;
  logic       id_ex_mem_rd_o, id_ex_mem_wr_o, id_ex_reg_wr_o, id_ex_mem_to_reg_o;
  logic       ex_mem_mem_rd_o, ex_mem_mem_wr_o, ex_mem_reg_wr_o, ex_mem_mem_to_reg_o;
  logic       mem_wb_reg_wr_o, mem_wb_mem_to_reg_o;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  bit done   = 1'b0;

  typedef struct packed { logic [8:0] bits; } item_t;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #10 clk_i = ~clk_i;

  ctrl_pipe u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .opcode_i(opcode_i),
    .id_ex_reg_dst_o(id_ex_reg_dst_o), .id_ex_alu_op_o(id_ex_alu_op_o),
    .id_ex_alu_src_o(id_ex_alu_src_o), .id_ex_branch_o(id_ex_branch_o),
    .id_ex_mem_rd_o(id_ex_mem_rd_o), .id_ex_mem_wr_o(id_ex_mem_wr_o),
    .id_ex_reg_wr_o(id_ex_reg_wr_o), .id_ex_mem_to_reg_o(id_ex_mem_to_reg_o),
    .ex_mem_mem_rd_o(ex_mem_mem_rd_o), .ex_mem_mem_wr_o(ex_mem_mem_wr_o),
    .ex_mem_reg_wr_o(ex_mem_reg_wr_o), .ex_mem_mem_to_reg_o(ex_mem_mem_to_reg_o),
    .mem_wb_reg_wr_o(mem_wb_reg_wr_o), .mem_wb_mem_to_reg_o(mem_wb_mem_to_reg_o)
  );

  function automatic logic [8:0] id_ex_bits();
    return {id_ex_reg_dst_o, id_ex_alu_op_o, id_ex_alu_src_o, id_ex_branch_o,
            id_ex_mem_rd_o, id_ex_mem_wr_o, id_ex_reg_wr_o, id_ex_mem_to_reg_o};
  endfunction

  function automatic logic [8:0] all_bits();
    return {3'b000, ex_mem_mem_rd_o, ex_mem_mem_wr_o, ex_mem_reg_wr_o,
            ex_mem_mem_to_reg_o, mem_wb_reg_wr_o, mem_wb_mem_to_reg_o} | id_ex_bits();
  endfunction

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // expected bundle from the requirement table
  task automatic drive(logic [5:0] op, logic fl);
    logic [8:0] e;
    string t;
    case (op)
      6'h00: begin e = 9'b1_10_0_0_0_0_1_0; t = "R1"; end
      6'h23: begin e = 9'b0_00_1_0_1_0_1_1; t = "R2"; end
      6'h2B: begin e = 9'b0_00_1_0_0_1_0_0; t = "R3"; end
      6'h04: begin e = 9'b0_01_0_1_0_0_0_0; t = "R4"; end
      default: begin e = 9'b0; t = "R5"; end
    endcase
    if (fl) begin e = 9'b0; t = "R6"; end
    opcode_i = op;
    flush_i  = fl;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk_i);
  endtask

  // monitor: compare each stage against bundles issued 0, 1 and 2 cycles back
  initial begin
    logic [8:0] p1, p2, e;
    string t;
    p1 = '0;
    p2 = '0;
    forever begin
      @(posedge clk_i);
      #5;
      if (mon_en && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, id_ex_bits(), e);
        chk("R7", {ex_mem_mem_rd_o, ex_mem_mem_wr_o, ex_mem_reg_wr_o, ex_mem_mem_to_reg_o},
            {5'b0, p1[3:0]});
        chk("R8 R10", {mem_wb_reg_wr_o, mem_wb_mem_to_reg_o}, {7'b0, p2[1:0]});
        p2 = p1;
        p1 = e;
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #5;
    chk("R9", all_bits(), 9'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    mon_en = 1'b1;
    drive(6'h00, 0);
    drive(6'h23, 0);
    drive(6'h2B, 0);   // R10: store in memory stage while load is at writeback
    drive(6'h04, 0);
    drive(6'h02, 0);
    drive(6'h3F, 0);
    drive(6'h23, 1);
    drive(6'h00, 0);
    drive(6'h00, 1);
    drive(6'h23, 0);
    drive(6'h23, 0);
    drive(6'h2B, 0);
    drive(6'h04, 0);
    drive(6'h00, 0);
    drive(6'h2B, 1);
    drive(6'h3F, 0);
    drive(6'h3F, 0);
    drive(6'h3F, 0);
    @(posedge clk_i);
    #6;
    mon_en = 1'b0;
    // mid-run reset with all stages loaded
    opcode_i = 6'h23;
    flush_i  = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R2", all_bits(), 9'b0_00_1_0_1_1_1_1);
    rst_ni = 1'b0;
    #1;
    chk("R9", all_bits(), 9'b0);
    @(posedge clk_i);
    #5;
    chk("R9", all_bits(), 9'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule